// File: doc/BRIEF.md
# Local-Bus Register Bank

This block holds a set of software-writable control registers behind a simple local bus. The bus carries an address, a write data word, a write enable and a read strobe. Every register sits at a fixed offset from a configurable base address. Each one has its own width and its own signedness, both set by parameters. A register is one of three kinds. A held register keeps its value. A pulse register presents the written value for one clock and then returns to zero, which suits clear and trigger actions. A strobe register passes the live write data and a one-cycle write-enable flag straight to a consumer, for example a FIFO push.

A block of array entries sits in its own region of the address space. That region is selected by comparing the upper address bits with a block number. The low address bits then pick the entry. A readback mirror, enabled by a parameter, returns the last written value of every register and array entry narrower than 32 bits. Read data comes back one cycle after the read strobe.

Top module: `lb_regbank`

## Requirements
- R1: After reset, every held register, every pulse output, every array entry, `reg_stb`, `lb_rdata` and `lb_rvalid` are zero.
- R2: A held register at address BASE_ADDR+i loads on a clock edge where `lb_we` is high and `lb_addr` equals that address. The new value shows on its `reg_val` slot (bits i*DATA_W upward) from the next cycle. The register keeps its value on every other edge.
- R3: Each `reg_val` slot carries only the low REG_W[i] bits of the written word. Those bits are sign-extended to DATA_W when REG_SIGNED[i] is set, and zero-extended otherwise.
- R4: A pulse register shows the written value on its slot for exactly the one cycle after the write and is zero after that. When it is written on consecutive cycles, it shows each written value in turn with no zero cycle between them.
- R5: A strobe register raises its `reg_stb` bit, and shows the current `lb_wdata` on its slot, in the same cycle that `lb_we` is high with its address. `reg_stb` bits of other kinds are always zero, and `reg_stb` is zero whenever `lb_we` is low.
- R6: An array entry is written when `lb_addr[ADDR_W-1:ARR_IDX_W]` equals ARR_BLOCK. The low ARR_IDX_W bits select the entry. Entry j appears zero-extended-free as ARR_W bits at `arr_val[j*ARR_W +: ARR_W]`, and entries that are not written keep their values.
- R7: With the mirror enabled, a read of a register narrower than 32 bits returns the same extended value as its slot. For pulse and strobe registers it returns the last written value. A read of an array entry narrower than 32 bits returns that entry zero-extended.
- R8: `lb_rvalid` is high exactly in the cycle after `lb_rd`, with the read data in `lb_rdata`. A read of a 32-bit register or of an unmapped address returns zero, and `lb_rdata` is zero when no read was requested.
- R9: A write to an address that hits no register and no array entry changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lb_addr | input | ADDR_W | Bus address |
| lb_wdata | input | DATA_W | Write data |
| lb_we | input | 1 | Write enable |
| lb_rd | input | 1 | Read strobe |
| reg_val | output | N_REG*DATA_W | One extended DATA_W slot per register |
| reg_stb | output | N_REG | Write flag for strobe-kind registers |
| arr_val | output | 2**ARR_IDX_W*ARR_W | Array entries, packed |
| lb_rdata | output | DATA_W | Registered read data |
| lb_rvalid | output | 1 | Read data valid |

## Verification
The assertions assume that `lb_we` and `lb_rd` are known after reset and never high in the same cycle. They also assume that the scalar addresses and the array region do not overlap, and that the bus is stable around each rising edge. The bench drives every input on the falling edge and holds it for a whole period. It never issues a read in the same cycle as a write. It keeps the default map, where the scalar slots and the array block are disjoint. These limits keep the exclusive-decode and read-latency properties meaningful without constraining the function under test.

// File: rtl/lb_regbank_pkg.sv
package lb_regbank_pkg;

    localparam int KIND_HOLD   = 0;
    localparam int KIND_PULSE  = 1;
    localparam int KIND_STROBE = 2;

    localparam int MIRROR_MAX_W = 32;

endpackage

// File: rtl/lb_addr_decode.sv
module lb_addr_decode #(
    parameter int          ADDR_W    = 12,
    parameter int          N_REG     = 6,
    parameter int unsigned BASE_ADDR = 32'h40,
    parameter int          ARR_IDX_W = 3,
    parameter int unsigned ARR_BLOCK = 32'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    output logic [N_REG-1:0]     hit,
    output logic                 arr_hit,
    output logic [ARR_IDX_W-1:0] arr_idx
);

    localparam int HI_W = ADDR_W - ARR_IDX_W;

    for (genvar i = 0; i < N_REG; i++) begin : g_hit
        assign hit[i] = (addr == ADDR_W'(BASE_ADDR + i));
    end

    assign arr_hit = (addr[ADDR_W-1:ARR_IDX_W] == HI_W'(ARR_BLOCK));
    assign arr_idx = addr[ARR_IDX_W-1:0];

    AST_DEC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_hit, hit})); // R6

endmodule

// File: rtl/lb_reg_slot.sv
module lb_reg_slot
    import lb_regbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int W      = 16,
    parameter int KIND   = KIND_HOLD,
    parameter bit SIGNED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] val,
    output logic              stb,
    output logic [DATA_W-1:0] mirror
);

    localparam int SH = DATA_W - W;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] mir;
    } slot_t;

    slot_t             s_d, s_q;
    logic [DATA_W-1:0] wsh;
    logic [DATA_W-1:0] wext;

    always_comb begin
        wsh  = wdata << SH;
        wext = SIGNED ? DATA_W'($signed(wsh) >>> SH) : (wsh >> SH);
    end

    always_comb begin
        s_d = s_q;
        if (KIND != KIND_HOLD) s_d.val = '0;
        if (wr_hit) begin
            if (KIND != KIND_STROBE) s_d.val = wext;
            s_d.mir = wext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign val    = (KIND == KIND_STROBE) ? wext : s_q.val;
    assign stb    = (KIND == KIND_STROBE) ? wr_hit : 1'b0;
    assign mirror = s_q.mir;

    if (KIND == KIND_HOLD) begin : g_ast_hold
        AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_hit |=> $stable(val)); // R2
        AST_HOLD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit |=> (val == $past(wext))); // R2
    end else if (KIND == KIND_PULSE) begin : g_ast_pulse
        AST_PULSE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_hit |=> (val == '0)); // R4
        AST_PULSE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit |=> (val == $past(wext))); // R4
    end else begin : g_ast_strobe
        AST_STB_MIRRORED: assert property (@(posedge clk) disable iff (!rst_n)
            stb |=> (mirror == $past(val))); // R7
    end

endmodule

// File: rtl/lb_reg_array.sv
module lb_reg_array #(
    parameter int ARR_W     = 10,
    parameter int ARR_IDX_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_hit,
    input  logic [ARR_IDX_W-1:0]           idx,
    input  logic [ARR_W-1:0]               wdata,
    output logic [(1<<ARR_IDX_W)*ARR_W-1:0] arr_flat,
    output logic [ARR_W-1:0]               rd_entry
);

    localparam int DEPTH = 1 << ARR_IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][ARR_W-1:0] mem;
    } arr_t;

    arr_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (wr_hit) a_d.mem[idx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign arr_flat = a_q.mem;
    assign rd_entry = a_q.mem[idx];

    AST_ARR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(arr_flat)); // R6

endmodule

// File: rtl/lb_regbank.sv
module lb_regbank
    import lb_regbank_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter int          N_REG      = 6,
    parameter int unsigned BASE_ADDR  = 32'h40,
    parameter int          REG_W      [N_REG] = '{16, 12, 1, 8, 16, 32},
    parameter int          REG_KIND   [N_REG] = '{KIND_HOLD, KIND_HOLD, KIND_PULSE,
                                                 KIND_PULSE, KIND_STROBE, KIND_HOLD},
    parameter bit          REG_SIGNED [N_REG] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    parameter int          ARR_IDX_W  = 3,
    parameter int          ARR_W      = 10,
    parameter int unsigned ARR_BLOCK  = 32'h20,
    parameter bit          MIRROR_EN  = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   lb_addr,
    input  logic [DATA_W-1:0]                   lb_wdata,
    input  logic                                lb_we,
    input  logic                                lb_rd,
    output logic [N_REG*DATA_W-1:0]             reg_val,
    output logic [N_REG-1:0]                    reg_stb,
    output logic [(1<<ARR_IDX_W)*ARR_W-1:0]     arr_val,
    output logic [DATA_W-1:0]                   lb_rdata,
    output logic                                lb_rvalid
);

    localparam bit ARR_READABLE = MIRROR_EN && (ARR_W < MIRROR_MAX_W);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } rd_t;

    function automatic bit slot_readable(int i);
        return MIRROR_EN && (REG_W[i] < MIRROR_MAX_W);
    endfunction

    logic [N_REG-1:0]     hit;
    logic                 arr_hit;
    logic [ARR_IDX_W-1:0] arr_idx;
    logic [ARR_W-1:0]     arr_entry;
    logic [DATA_W-1:0]    mir_raw   [N_REG];
    logic [DATA_W-1:0]    mir_gated [N_REG];
    logic [DATA_W-1:0]    rd_val;
    rd_t                  r_d, r_q;

    lb_addr_decode #(
        .ADDR_W    (ADDR_W),
        .N_REG     (N_REG),
        .BASE_ADDR (BASE_ADDR),
        .ARR_IDX_W (ARR_IDX_W),
        .ARR_BLOCK (ARR_BLOCK)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (lb_addr),
        .hit     (hit),
        .arr_hit (arr_hit),
        .arr_idx (arr_idx)
    );

    for (genvar i = 0; i < N_REG; i++) begin : g_slot
        lb_reg_slot #(
            .DATA_W (DATA_W),
            .W      (REG_W[i]),
            .KIND   (REG_KIND[i]),
            .SIGNED (REG_SIGNED[i])
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (lb_we && hit[i]),
            .wdata  (lb_wdata),
            .val    (reg_val[i*DATA_W +: DATA_W]),
            .stb    (reg_stb[i]),
            .mirror (mir_raw[i])
        );
    end

    lb_reg_array #(
        .ARR_W     (ARR_W),
        .ARR_IDX_W (ARR_IDX_W)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (lb_we && arr_hit),
        .idx      (arr_idx),
        .wdata    (lb_wdata[ARR_W-1:0]),
        .arr_flat (arr_val),
        .rd_entry (arr_entry)
    );

    always_comb begin
        for (int i = 0; i < N_REG; i++) begin
            mir_gated[i] = slot_readable(i) ? mir_raw[i] : '0;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (hit[i]) rd_val = mir_gated[i];
        end
        if (arr_hit && ARR_READABLE) rd_val = DATA_W'(arr_entry);
    end

    always_comb begin
        r_d.rdata  = lb_rd ? rd_val : '0;
        r_d.rvalid = lb_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lb_rdata  = r_q.rdata;
    assign lb_rvalid = r_q.rvalid;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lb_rd |=> lb_rvalid); // R8
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lb_rd |=> (!lb_rvalid && lb_rdata == '0)); // R8
    AST_STB_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_stb) |-> lb_we); // R5
    AST_STB_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_stb)); // R5
    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_we && !arr_hit && hit == '0) |=> $stable(arr_val)); // R9

endmodule

// File: tb/lb_regbank_tb_top.sv
module lb_regbank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int NV         = 10;

    // {address, write data, expected readback}
    localparam logic [75:0] VEC [NV] = '{
        {12'h040, 32'h0001_ABCD, 32'h0000_ABCD},
        {12'h041, 32'h0000_0800, 32'hFFFF_F800},
        {12'h041, 32'h0000_07FF, 32'h0000_07FF},
        {12'h042, 32'h0000_0001, 32'h0000_0001},
        {12'h043, 32'h0000_01F5, 32'h0000_00F5},
        {12'h044, 32'h0001_2345, 32'h0000_2345},
        {12'h045, 32'hDEAD_BEEF, 32'h0000_0000},
        {12'h103, 32'h0000_07FF, 32'h0000_03FF},
        {12'h107, 32'h0000_0155, 32'h0000_0155},
        {12'h0F0, 32'h0000_0005, 32'h0000_0000}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [11:0]    lb_addr = '0;
    logic [DW-1:0]  lb_wdata = '0;
    logic           lb_we = 1'b0;
    logic           lb_rd = 1'b0;
    logic [6*DW-1:0] reg_val;
    logic [5:0]     reg_stb;
    logic [79:0]    arr_val;
    logic [DW-1:0]  lb_rdata;
    logic           lb_rvalid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lb_regbank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lb_addr   (lb_addr),
        .lb_wdata  (lb_wdata),
        .lb_we     (lb_we),
        .lb_rd     (lb_rd),
        .reg_val   (reg_val),
        .reg_stb   (reg_stb),
        .arr_val   (arr_val),
        .lb_rdata  (lb_rdata),
        .lb_rvalid (lb_rvalid)
    );

    task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] slot(input int i);
        return reg_val[i*DW +: DW];
    endfunction

    task automatic do_write(input logic [11:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        lb_addr = a; lb_wdata = d; lb_we = 1'b1;
        @(negedge clk);
        lb_we = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a);
        @(negedge clk);
        lb_addr = a; lb_rd = 1'b1;
        @(negedge clk);
        lb_rd = 1'b0;
    endtask

    initial begin
        logic [6*DW-1:0] snap_reg;
        logic [79:0]     snap_arr;
        logic [6*DW-1:0] mask;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reg_val", 192'(reg_val), 192'(0));
        check("R1 arr_val", 192'(arr_val), 192'(0));
        check("R1 rd", 192'({reg_stb, lb_rvalid, lb_rdata}), 192'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R7 R8: write then read back each table entry
        for (int k = 0; k < NV; k++) begin
            do_write(VEC[k][75:64], VEC[k][63:32]);
            do_read(VEC[k][75:64]);
            check("R7 R8 readback", 192'(lb_rdata), 192'(VEC[k][31:0]));
            check("R8 rvalid", 192'(lb_rvalid), 192'(1));
        end
        @(negedge clk);
        check("R8 idle rdata", 192'({lb_rvalid, lb_rdata}), 192'(0));

        // R6: array entries on the port
        check("R6 entry3", 192'(arr_val[3*10 +: 10]), 192'(10'h3FF));
        check("R6 entry7", 192'(arr_val[7*10 +: 10]), 192'(10'h155));
        check("R6 entry0", 192'(arr_val[0 +: 10]), 192'(0));

        // R2 R3: held values and extension on the port
        check("R2 slot0", 192'(slot(0)), 192'(32'h0000_ABCD));
        check("R3 slot5 full", 192'(slot(5)), 192'(32'hDEAD_BEEF));
        do_write(12'h041, 32'h0000_0A5A);
        check("R3 signed slot1", 192'(slot(1)), 192'(32'hFFFF_FA5A));
        do_write(12'h040, 32'h0000_1234);
        do_write(12'h041, 32'h0000_0001);
        check("R2 slot0 kept", 192'(slot(0)), 192'(32'h0000_1234));

        // R4: single pulse, then back-to-back pulses
        do_write(12'h042, 32'h0000_0003);
        check("R4 pulse high", 192'(slot(2)), 192'(1));
        @(negedge clk);
        check("R4 pulse low", 192'(slot(2)), 192'(0));
        lb_addr = 12'h043; lb_wdata = 32'h11; lb_we = 1'b1;
        @(negedge clk);
        lb_wdata = 32'h22;
        check("R4 b2b first", 192'(slot(3)), 192'(32'h11));
        @(negedge clk);
        lb_we = 1'b0;
        check("R4 b2b second", 192'(slot(3)), 192'(32'h22));
        @(negedge clk);
        check("R4 b2b drop", 192'(slot(3)), 192'(0));

        // R5: strobe register
        lb_addr = 12'h044; lb_wdata = 32'h000A_BCD5; lb_we = 1'b1;
        #1;
        check("R5 stb bit", 192'(reg_stb), 192'(6'b010000));
        check("R5 stb data", 192'(slot(4)), 192'(32'h0000_BCD5));
        @(negedge clk);
        lb_we = 1'b0;
        #1;
        check("R5 stb low", 192'(reg_stb), 192'(0));
        lb_addr = 12'h040; lb_we = 1'b1;
        #1;
        check("R5 no stb held", 192'(reg_stb), 192'(0));
        @(negedge clk);
        lb_we = 1'b0;

        // R9: unmapped writes change nothing (strobe slot follows wdata by design)
        mask = '1;
        mask[4*DW +: DW] = '0;
        @(negedge clk);
        snap_reg = reg_val & mask;
        snap_arr = arr_val;
        lb_addr = 12'h0F0; lb_wdata = 32'hFFFF_FFFF; lb_we = 1'b1;
        #1;
        check("R9 no stb", 192'(reg_stb), 192'(0));
        @(negedge clk);
        lb_addr = 12'h108;
        @(negedge clk);
        lb_addr = 12'h03F;
        @(negedge clk);
        lb_we = 1'b0;
        @(negedge clk);
        check("R9 reg_val kept", 192'(reg_val & mask), 192'(snap_reg));
        check("R9 arr_val kept", 192'(arr_val), 192'(snap_arr));

        // R1: reset again clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", 192'(reg_val & mask), 192'(0));
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule